// File: doc/BRIEF.md
# Masked Vector AND Unit

This block computes a lane-wise bitwise AND of two packed vectors of 32-bit elements and writes the result into a 512-bit destination value. The element contents are treated as raw bits: the operation raises no floating-point exceptions and ignores rounding state. Three operating modes decide how the destination is formed: a legacy mode, a plain extended mode and a masked extended mode. The two extended modes accept a vector length of 128, 256 or 512 bits, which gives 4, 8 or 16 active lanes.

In masked mode, each lane has a write-enable bit. A disabled lane either keeps its old destination element (merging) or is cleared (zeroing). A flag that marks the mask as the reserved "no mask" register turns on every lane. When broadcast is requested and the second operand comes from memory, the low 32-bit element of the second source is used in every lane. In legacy mode, the destination doubles as the first source, so only the low 128 bits are computed. The block samples its inputs when `in_valid` is high and presents the registered result with a one-cycle `out_valid` pulse on the following cycle.

Top module: `vec_and_unit`

## Requirements
- R1: In masked mode (mode 2'b10 or 2'b11), a lane j inside the vector length whose bit `kmask[j]` is 1 receives `src_a` lane j AND `src_b` lane j. Lane j occupies bits 32*j+31:32*j.
- R2: In masked mode with `zero_mask`=0, a lane inside the vector length whose mask bit is 0 keeps its `dst_old` element.
- R3: In masked mode with `zero_mask`=1, a lane inside the vector length whose mask bit is 0 becomes zero.
- R4: In masked mode with `no_mask`=1, every lane inside the vector length is written with the AND, whatever `kmask` and `zero_mask` hold.
- R5: In masked mode with both `bcast` and `b_from_mem` at 1, every lane uses `src_b[31:0]` as its second operand. If `bcast`=1 and `b_from_mem`=0, each lane uses its own `src_b` element.
- R6: In masked mode, all destination bits at or above the vector length are zero. `vlen` 2'b00 selects 128 bits, 2'b01 selects 256 bits, and 2'b1x selects 512 bits.
- R7: Mask bits at or above the active lane count have no effect on the result.
- R8: In plain extended mode (mode 2'b01), every lane inside the vector length receives `src_a` AND `src_b`. Bits above the vector length are zero. `kmask`, `no_mask`, `zero_mask`, `bcast` and `b_from_mem` are ignored.
- R9: In legacy mode (mode 2'b00), bits 127:0 receive `dst_old[127:0]` AND `src_b[127:0]`, and bits 511:128 keep `dst_old[511:128]`. `src_a`, `vlen`, the mask inputs and the broadcast inputs are ignored.
- R10: A result is captured on the clock edge where `in_valid` is 1. `out_valid` is 1 during exactly the following cycle. While `in_valid` is 0, `dst_new` holds its value.
- R11: A synchronous `rst` clears `dst_new` and `out_valid`, and it takes priority over an `in_valid` on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample the inputs on this edge |
| mode | input | 2 | 00 legacy, 01 plain extended, 1x masked |
| vlen | input | 2 | 00 128-bit, 01 256-bit, 1x 512-bit |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| dst_old | input | 512 | Previous destination value |
| kmask | input | 16 | Per-lane write enables |
| no_mask | input | 1 | Mask is the reserved all-enable register |
| zero_mask | input | 1 | 1 zeroing, 0 merging for disabled lanes |
| bcast | input | 1 | Broadcast request |
| b_from_mem | input | 1 | Second source was read from memory |
| out_valid | output | 1 | Result valid pulse |
| dst_new | output | 512 | Registered destination result |

## Verification
Two functions can act on the same lanes in one operation: broadcast selection and merge or zero masking. The bench therefore runs broadcast vectors under merging with a mixed mask. There it checks that the enabled lanes carry `src_a` AND the low `src_b` element, while the disabled lanes keep their old content. Reset and a valid input can also land on the same edge. The bench asserts both together and checks that `out_valid` stays low and `dst_new` is zero on the next cycle. It also confirms that a mid-stream reset wipes a non-zero result.

// File: rtl/vec_and_unit.sv
module vec_and_unit #(
  parameter int ELEM_W    = 32,
  parameter int MAX_LANES = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [1:0]                    mode,
  input  logic [1:0]                    vlen,
  input  logic [ELEM_W*MAX_LANES-1:0]   src_a,
  input  logic [ELEM_W*MAX_LANES-1:0]   src_b,
  input  logic [ELEM_W*MAX_LANES-1:0]   dst_old,
  input  logic [MAX_LANES-1:0]          kmask,
  input  logic                          no_mask,
  input  logic                          zero_mask,
  input  logic                          bcast,
  input  logic                          b_from_mem,
  output logic                          out_valid,
  output logic [ELEM_W*MAX_LANES-1:0]   dst_new
);
  localparam int DW      = ELEM_W * MAX_LANES;
  localparam int LEG_LN  = MAX_LANES / 4;
  localparam int LEG_W   = ELEM_W * LEG_LN;
  localparam int LW      = $clog2(MAX_LANES) + 1;

  logic [LW-1:0] lanes_act;
  logic          is_leg, is_plain, use_bc;
  logic [DW-1:0] nxt;

  assign lanes_act = (vlen == 2'b00) ? LW'(LEG_LN) :
                     (vlen == 2'b01) ? LW'(MAX_LANES / 2) : LW'(MAX_LANES);
  assign is_leg    = (mode == 2'b00);
  assign is_plain  = (mode == 2'b01);
  assign use_bc    = bcast & b_from_mem;

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    logic [ELEM_W-1:0] a_el, b_el, o_el, prod;
    logic              in_vl, wr_en;
    assign a_el  = src_a[j*ELEM_W +: ELEM_W];
    assign o_el  = dst_old[j*ELEM_W +: ELEM_W];
    assign b_el  = (use_bc && !is_plain) ? src_b[ELEM_W-1:0] : src_b[j*ELEM_W +: ELEM_W];
    assign prod  = a_el & b_el;
    assign in_vl = (LW'(j) < lanes_act);
    assign wr_en = no_mask | kmask[j];
    if (j < LEG_LN) begin : g_low
      assign nxt[j*ELEM_W +: ELEM_W] =
        is_leg   ? (o_el & src_b[j*ELEM_W +: ELEM_W]) :
        !in_vl   ? '0 :
        is_plain ? prod :
        wr_en    ? prod :
        zero_mask ? '0 : o_el;
    end else begin : g_high
      assign nxt[j*ELEM_W +: ELEM_W] =
        is_leg   ? o_el :
        !in_vl   ? '0 :
        is_plain ? prod :
        wr_en    ? prod :
        zero_mask ? '0 : o_el;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dst_new   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) dst_new <= nxt;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(dst_new)); // R10
  AST_LEGACY_UPPER: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b00) |=> dst_new[DW-1:LEG_W] == $past(dst_old[DW-1:LEG_W])); // R9
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode != 2'b00 && vlen == 2'b00) |=> dst_new[DW-1:LEG_W] == '0); // R6
  AST_ZERO_ALL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode[1] && zero_mask && !no_mask && kmask == '0) |=> dst_new == '0); // R3
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && dst_new == '0)); // R11
endmodule

// File: tb/vec_and_unit_bench.sv
`timescale 1ns/1ps
module vec_and_unit_bench;
  localparam int DW = 512;
  localparam int NL = 16;

  logic          clk = 1'b0;
  logic          rst, in_valid, no_mask, zero_mask, bcast, b_from_mem;
  logic [1:0]    mode, vlen;
  logic [DW-1:0] src_a, src_b, dst_old;
  logic [NL-1:0] kmask;
  logic          out_valid;
  logic [DW-1:0] dst_new;

  int  n_run = 0;
  int  n_bad = 0;
  bit  done  = 0;

  always #2.5 clk = ~clk;

  vec_and_unit u_vec_and_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .vlen(vlen),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old), .kmask(kmask),
    .no_mask(no_mask), .zero_mask(zero_mask), .bcast(bcast),
    .b_from_mem(b_from_mem), .out_valid(out_valid), .dst_new(dst_new)
  );

  // {req[3:0], mode[1:0], vlen[1:0], no_mask, zero_mask, bcast, b_from_mem, kmask[15:0]}
  localparam logic [27:0] VEC [12] = '{
    {4'd1,  2'b10, 2'b10, 4'b0000, 16'hA5C3}, // R1 R2 merge mixed mask
    {4'd3,  2'b10, 2'b10, 4'b0100, 16'h0F0F}, // R3 zeroing
    {4'd4,  2'b10, 2'b10, 4'b1100, 16'h0000}, // R4 no-mask flag
    {4'd7,  2'b10, 2'b01, 4'b0000, 16'hFFFF}, // R7 R6 256-bit, high mask bits set
    {4'd7,  2'b10, 2'b00, 4'b0100, 16'hFFF0}, // R7 R6 128-bit zeroing
    {4'd5,  2'b10, 2'b10, 4'b0011, 16'h3C3C}, // R5 broadcast with merge
    {4'd5,  2'b11, 2'b01, 4'b0010, 16'h00FF}, // R5 broadcast without memory
    {4'd8,  2'b01, 2'b00, 4'b0100, 16'h0000}, // R8 plain 128
    {4'd8,  2'b01, 2'b01, 4'b0011, 16'h1234}, // R8 plain 256
    {4'd8,  2'b01, 2'b11, 4'b0000, 16'h0000}, // R8 plain 512
    {4'd9,  2'b00, 2'b00, 4'b0000, 16'h0000}, // R9 legacy
    {4'd9,  2'b00, 2'b10, 4'b0111, 16'h0000}  // R9 legacy ignores extras
  };

  function automatic logic [DW-1:0] pat(input int seed, input logic [31:0] salt);
    logic [DW-1:0] v;
    for (int l = 0; l < NL; l++)
      v[l*32 +: 32] = salt ^ (32'(seed) * 32'h01030507) ^ (32'(l) * 32'h11111111);
    return v;
  endfunction

  function automatic logic [DW-1:0] model(
      input logic [1:0] md, input logic [1:0] vl, input logic nm, input logic zm,
      input logic bc, input logic mem, input logic [NL-1:0] km,
      input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] o);
    logic [DW-1:0] r;
    int lanes;
    logic [31:0] bw;
    r = '0;
    if (md == 2'b00) begin
      r = o;
      r[127:0] = o[127:0] & b[127:0];
      return r;
    end
    lanes = (vl == 2'b00) ? 4 : (vl == 2'b01) ? 8 : 16;
    for (int l = 0; l < lanes; l++) begin
      bw = (md[1] && bc && mem) ? b[31:0] : b[l*32 +: 32];
      if (md == 2'b01 || nm || km[l]) r[l*32 +: 32] = a[l*32 +: 32] & bw;
      else if (!zm) r[l*32 +: 32] = o[l*32 +: 32];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue();
    @(negedge clk) in_valid = 1'b1;
    @(negedge clk) in_valid = 1'b0;
  endtask

  initial begin
    logic [DW-1:0] exp, held;
    rst = 1'b1; in_valid = 1'b0; mode = 2'b10; vlen = 2'b10;
    no_mask = 0; zero_mask = 0; bcast = 0; b_from_mem = 0; kmask = '0;
    src_a = '0; src_b = '0; dst_old = '0;
    repeat (3) @(negedge clk);
    check("R11 reset dst", dst_new, '0);
    check("R11 reset valid", DW'(out_valid), '0);
    rst = 1'b0;

    foreach (VEC[i]) begin
      {mode, vlen, no_mask, zero_mask, bcast, b_from_mem, kmask} = VEC[i][23:0];
      src_a   = pat(i, 32'hFF00_FF00);
      src_b   = pat(i + 7, 32'h0FF0_3CC3);
      dst_old = pat(i + 3, 32'hDEAD_BEEF);
      exp = model(mode, vlen, no_mask, zero_mask, bcast, b_from_mem, kmask, src_a, src_b, dst_old);
      issue();
      check($sformatf("R%0d vector %0d", VEC[i][27:24], i), dst_new, exp);
      check("R10 valid pulse", DW'(out_valid), DW'(1));
    end

    // R10: valid falls and result holds while inputs move with in_valid low
    held = dst_new;
    src_a = ~src_a; src_b = ~src_b; dst_old = ~dst_old; mode = 2'b01;
    @(negedge clk);
    check("R10 valid low", DW'(out_valid), '0);
    check("R10 hold", dst_new, held);

    // R11: reset and in_valid on the same edge
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    check("R11 reset wins dst", dst_new, '0);
    check("R11 reset wins valid", DW'(out_valid), '0);

    // R11: reset wipes a non-zero result
    mode = 2'b01; vlen = 2'b10; src_a = '1; src_b = '1;
    issue();
    check("R8 all ones", dst_new, '1);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R11 mid reset", dst_new, '0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule